// File: doc/BRIEF.md
# LCD Row Scan Shift Register

This block scans the common (row) electrodes of a dot-matrix LCD panel. A chain of `ROWS` one-bit stages carries a select token. Each active edge of a shift clock moves the token one row further. Two static strap inputs set how the chain runs. One sets the shift direction, and with it which edge data port takes serial data in and which one passes it out. The other sets whether the chain moves on the rising or the falling edge of the shift clock.

A third strap picks the timing source. As master, an internal divider makes the shift clock, places a select pulse at the input end once every `ROWS` shifts, and toggles the AC frame polarity at each frame start. All shared timing and data ports then drive. As slave, the generator is held idle. The frame polarity, the shift clock and the serial data then arrive from outside through a synchronizer. Each row leaves the block as a registered two-bit code of select flag and frame polarity. Downstream drivers turn that code into the panel voltages. Every bidirectional pin is split into input, output and output-enable signals.

Top module: `lcd_row_scan`

## Requirements
- R1: The synchronous reset clears every bit of `row_code` to 0 (all rows non-selected, polarity bit 0) while it is held, whatever the inputs.
- R2: With `dir_i` = 1, the serial input is taken from `left_i` into row 0, and every shift moves stage k to stage k+1.
- R3: With `dir_i` = 0, the serial input is taken from `right_i` into row `ROWS`-1, and every shift moves stage k to stage k-1.
- R4: With `phase_i` = 1, the chain shifts on a rising edge of the shift clock, and a falling edge leaves every row unchanged.
- R5: With `phase_i` = 0, the chain shifts on a falling edge of the shift clock, and a rising edge leaves every row unchanged.
- R6: In slave mode (`master_i` = 0), `frame_oe` and `scl_oe` are 0, the input-end data port has its enable at 0, and the output-end data port has its enable at 1.
- R7: In master mode (`master_i` = 1), `frame_oe`, `scl_oe`, `left_oe` and `right_oe` are all 1.
- R8: The output-end data port (`right_o` when `dir_i` = 1, `left_o` when `dir_i` = 0) carries the last stage of the chain. In master mode the input-end port carries the select pulse fed to the first stage.
- R9: `row_code[2k+1]` is the select flag of row k and `row_code[2k]` is the current frame polarity. In slave mode the polarity follows `frame_i`, and in master mode it equals `frame_o`.
- R10: In master mode, at most one row is selected at any time. Once the token is loaded, it advances by exactly one row in the chosen direction on each active edge of `scl_o`, and it wraps from the output end back to the input end.
- R11: In master mode, the frame polarity toggles once per `ROWS` shifts, at the shift that places the token in the input-end row.
- R12: In master mode, `scl_o` changes level every `CLK_HALF` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | Strap: 1 master (internal timing), 0 slave |
| dir_i | input | 1 | Strap: 1 left-in/right-out, 0 right-in/left-out |
| phase_i | input | 1 | Strap: 1 shift on rising edge, 0 on falling edge |
| frame_i | input | 1 | Frame polarity from outside (slave) |
| frame_o | output | 1 | Frame polarity from the generator (master) |
| frame_oe | output | 1 | Drive enable for the frame polarity pin |
| scl_i | input | 1 | Shift clock from outside (slave) |
| scl_o | output | 1 | Shift clock from the generator (master) |
| scl_oe | output | 1 | Drive enable for the shift clock pin |
| left_i | input | 1 | Left data port, input side |
| left_o | output | 1 | Left data port, output side |
| left_oe | output | 1 | Left data port drive enable |
| right_i | input | 1 | Right data port, input side |
| right_o | output | 1 | Right data port, output side |
| right_oe | output | 1 | Right data port drive enable |
| row_code | output | 2*ROWS | Per-row {select, polarity} codes, row k at bits 2k+1:2k |

## Verification
The bench builds the block with `ROWS` = 16 and `CLK_HALF` = 8. With only 16 stages, a token shifted in from outside reaches the output-end port after a short run. In master mode, more than two full frames pass, so the wrap from the last row back to the first and several polarity toggles are all seen. A half period of 8 cycles leaves room for the few register stages between a shift clock edge and `row_code`, so each row state can be read before the next edge.

// File: rtl/lcd_row_scan_pkg.sv
package lcd_row_scan_pkg;

  // Shift direction strap encoding
  typedef enum logic {
    SCAN_RIGHT_TO_LEFT = 1'b0,
    SCAN_LEFT_TO_RIGHT = 1'b1
  } scan_dir_e;

  // Per-row drive code handed to the level switches
  typedef struct packed {
    logic sel;   // row selected this line
    logic pol;   // AC frame polarity
  } row_drive_t;

endpackage

// File: rtl/row_scan_sync.sv
module row_scan_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/row_scan_timing.sv
module row_scan_timing #(
  parameter int ROWS     = 64,
  parameter int CLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic phase,
  output logic scl_q,
  output logic data_q,
  output logic m_q
);

  localparam int DIV_W  = $clog2(CLK_HALF + 1);
  localparam int LINE_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CLK_HALF - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(ROWS - 1);

  logic [DIV_W-1:0]  div_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              toward_inactive;

  // The coming toggle is the non-shifting edge when the clock currently
  // sits at the level the active edge ends on.
  assign toward_inactive = (scl_q == phase);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt  <= '0;
      scl_q    <= 1'b0;
      line_cnt <= LINE_LAST;
      data_q   <= 1'b0;
      m_q      <= 1'b0;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt <= '0;
      scl_q   <= ~scl_q;
      if (toward_inactive) begin
        if (line_cnt == LINE_LAST) begin
          line_cnt <= '0;
          data_q   <= 1'b1;
          m_q      <= ~m_q;
        end else begin
          line_cnt <= line_cnt + 1'b1;
          data_q   <= 1'b0;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/row_scan_edge.sv
module row_scan_edge (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic phase,
  output logic fire
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= src;
  end

  assign fire = phase ? (src & ~prev) : (~src & prev);

endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int ROWS = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift,
  input  logic            dir,
  input  logic            din,
  output logic [ROWS-1:0] stage,
  output logic            tail
);

  import lcd_row_scan_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else if (shift) begin
      if (scan_dir_e'(dir) == SCAN_LEFT_TO_RIGHT) stage <= {stage[ROWS-2:0], din};
      else                                        stage <= {din, stage[ROWS-1:1]};
    end
  end

  assign tail = dir ? stage[ROWS-1] : stage[0];

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan #(
  parameter int ROWS        = 64,
  parameter int CLK_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_i,
  input  logic              dir_i,
  input  logic              phase_i,
  input  logic              frame_i,
  output logic              frame_o,
  output logic              frame_oe,
  input  logic              scl_i,
  output logic              scl_o,
  output logic              scl_oe,
  input  logic              left_i,
  output logic              left_o,
  output logic              left_oe,
  input  logic              right_i,
  output logic              right_o,
  output logic              right_oe,
  output logic [2*ROWS-1:0] row_code
);

  import lcd_row_scan_pkg::*;

  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] raw_in, sync_in;
  logic s_frame, s_scl, s_left, s_right;
  logic gen_scl, gen_data, gen_m;
  logic clk_src, shift_en, chain_din, pol_cur, tail;
  logic [ROWS-1:0] stage;

  assign raw_in = {frame_i, scl_i, left_i, right_i};
  assign {s_frame, s_scl, s_left, s_right} = sync_in;

  row_scan_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  row_scan_timing #(.ROWS(ROWS), .CLK_HALF(CLK_HALF)) u_timing (
    .clk(clk), .rst(rst), .run(master_i), .phase(phase_i),
    .scl_q(gen_scl), .data_q(gen_data), .m_q(gen_m)
  );

  assign clk_src   = master_i ? gen_scl  : s_scl;
  assign chain_din = master_i ? gen_data : (dir_i ? s_left : s_right);
  assign pol_cur   = master_i ? gen_m    : s_frame;

  row_scan_edge u_edge (
    .clk(clk), .rst(rst), .src(clk_src), .phase(phase_i), .fire(shift_en)
  );

  row_scan_chain #(.ROWS(ROWS)) u_chain (
    .clk(clk), .rst(rst), .shift(shift_en), .dir(dir_i),
    .din(chain_din), .stage(stage), .tail(tail)
  );

  // Port direction: timing pins drive only as master; data ports drive
  // at the output end always and at the input end only as master.
  assign frame_o  = gen_m;
  assign frame_oe = master_i;
  assign scl_o    = gen_scl;
  assign scl_oe   = master_i;
  assign left_o   = dir_i ? gen_data : tail;
  assign right_o  = dir_i ? tail : gen_data;
  assign left_oe  = master_i | ~dir_i;
  assign right_oe = master_i | dir_i;

  // Registered per-row drive codes
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    row_drive_t code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else     code_q <= '{sel: stage[k], pol: pol_cur};
    end
    assign row_code[2*k+1:2*k] = code_q;
  end

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int ROWS     = 64,
  parameter int CLK_HALF = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              master_i,
  input logic              dir_i,
  input logic              frame_oe,
  input logic              scl_oe,
  input logic              left_oe,
  input logic              right_oe,
  input logic              scl_o,
  input logic [2*ROWS-1:0] row_code
);

  localparam int CNT_W = $clog2(CLK_HALF + 2) + 1;

  logic [ROWS-1:0]  sel_vec;
  logic [CNT_W-1:0] since_edge;
  logic             scl_prev, toggled_once;

  always_comb begin
    for (int i = 0; i < ROWS; i++) sel_vec[i] = row_code[2*i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_edge   <= '0;
      scl_prev     <= 1'b0;
      toggled_once <= 1'b0;
    end else begin
      scl_prev <= scl_o;
      if (scl_o != scl_prev) begin
        since_edge   <= '0;
        toggled_once <= 1'b1;
      end else begin
        since_edge <= since_edge + 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (row_code == '0));

  p_slave_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !master_i |-> (!frame_oe && !scl_oe && (left_oe == !dir_i) && (right_oe == dir_i)));

  p_master_oe_r7: assert property (@(posedge clk) disable iff (rst)
    master_i |-> (frame_oe && scl_oe && left_oe && right_oe));

  p_single_row_r10: assert property (@(posedge clk) disable iff (rst)
    master_i |-> $onehot0(sel_vec));

  p_scl_half_r12: assert property (@(posedge clk) disable iff (rst)
    (master_i && toggled_once && (scl_o != scl_prev)) |-> (since_edge == CNT_W'(CLK_HALF - 1)));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(.ROWS(ROWS), .CLK_HALF(CLK_HALF)) u_chk (.*);

// File: tb/tb_lcd_row_scan.sv
module tb_lcd_row_scan;

  localparam int ROWS     = 16;
  localparam int CLK_HALF = 8;
  localparam int SETTLE   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_i = 1'b0, dir_i = 1'b1, phase_i = 1'b1;
  logic frame_i = 1'b0, scl_i = 1'b0, left_i = 1'b0, right_i = 1'b0;
  logic frame_o, frame_oe, scl_o, scl_oe;
  logic left_o, left_oe, right_o, right_oe;
  logic [2*ROWS-1:0] row_code;

  int checks = 0;
  int fails  = 0;
  logic [ROWS-1:0] mdl;

  always #2.5 clk = ~clk;

  lcd_row_scan #(.ROWS(ROWS), .CLK_HALF(CLK_HALF)) dut (
    .clk(clk), .rst(rst), .master_i(master_i), .dir_i(dir_i), .phase_i(phase_i),
    .frame_i(frame_i), .frame_o(frame_o), .frame_oe(frame_oe),
    .scl_i(scl_i), .scl_o(scl_o), .scl_oe(scl_oe),
    .left_i(left_i), .left_o(left_o), .left_oe(left_oe),
    .right_i(right_i), .right_o(right_o), .right_oe(right_oe),
    .row_code(row_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] sel_bits();
    logic [ROWS-1:0] s;
    for (int i = 0; i < ROWS; i++) s[i] = row_code[2*i+1];
    return s;
  endfunction

  function automatic logic [ROWS-1:0] pol_bits();
    logic [ROWS-1:0] s;
    for (int i = 0; i < ROWS; i++) s[i] = row_code[2*i];
    return s;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic d, input logic p);
    rst = 1'b1;
    master_i = m; dir_i = d; phase_i = p;
    frame_i = 1'b0; scl_i = 1'b0; left_i = 1'b0; right_i = 1'b0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    mdl = '0;
  endtask

  // One full slave shift clock pulse carrying bit b; checks shift and ignored edge
  task automatic shift_bit(input logic b);
    logic [ROWS-1:0] s0, s1, s2;
    string rq;
    rq = dir_i ? "R2" : "R3";
    if (dir_i) left_i = b; else right_i = b;
    wait_cyc(SETTLE);
    s0 = sel_bits();
    scl_i = 1'b1;
    wait_cyc(SETTLE);
    s1 = sel_bits();
    scl_i = 1'b0;
    wait_cyc(SETTLE);
    s2 = sel_bits();
    if (dir_i) mdl = {mdl[ROWS-2:0], b};
    else       mdl = {b, mdl[ROWS-1:1]};
    if (phase_i) begin
      chk(s1 == mdl, {rq, "/R4"}, "rows after rising edge", 64'(s1), 64'(mdl));
      chk(s2 == s1, "R4", "falling edge ignored", 64'(s2), 64'(s1));
    end else begin
      chk(s1 == s0, "R5", "rising edge ignored", 64'(s1), 64'(s0));
      chk(s2 == mdl, {rq, "/R5"}, "rows after falling edge", 64'(s2), 64'(mdl));
    end
  endtask

  // {dir, phase, serial byte shifted lsb first}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b1, 8'hA5},
    {1'b0, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'h81},
    {1'b0, 1'b0, 8'h5E},
    {1'b1, 1'b1, 8'hFF},
    {1'b0, 1'b0, 8'h01}
  };

  // Half-period monitor of the generated shift clock (R12)
  logic mon_en = 1'b0, mon_prev = 1'b0, mon_seen = 1'b0;
  int   mon_cnt = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_prev = 1'b0; mon_seen = 1'b0; mon_cnt = 0;
    end else if (scl_o != mon_prev) begin
      if (mon_seen) chk(mon_cnt == CLK_HALF, "R12", "scl_o half period", 64'(mon_cnt), 64'(CLK_HALF));
      mon_prev = scl_o; mon_seen = 1'b1; mon_cnt = 1;
    end else begin
      mon_cnt++;
    end
  end

  task automatic master_run(input logic d, input logic p);
    int pos, in_end, out_end, nxt;
    bit have_pos, have_entry;
    logic last_m, last_scl, in_o, out_o;
    logic [ROWS-1:0] s;
    do_reset(1'b1, d, p);
    mon_en = 1'b1;
    chk(frame_oe && scl_oe && left_oe && right_oe, "R7", "master enables",
        64'({frame_oe, scl_oe, left_oe, right_oe}), 64'hF);
    in_end  = d ? 0 : ROWS - 1;
    out_end = d ? ROWS - 1 : 0;
    have_pos = 1'b0; have_entry = 1'b0; pos = 0; last_m = 1'b0;
    last_scl = scl_o;
    for (int e = 0; e < 2 * ROWS + 4; e++) begin
      // wait for the next active edge of scl_o
      forever begin
        @(negedge clk);
        if (scl_o != last_scl) begin
          last_scl = scl_o;
          if (scl_o == p) break;
        end
      end
      wait_cyc(3);
      s = sel_bits();
      in_o  = d ? left_o : right_o;
      out_o = d ? right_o : left_o;
      chk($countones(s) <= 1, "R10", "at most one row selected", 64'(s), 64'(0));
      chk(pol_bits() == {ROWS{frame_o}}, "R9", "row polarity equals frame_o",
          64'(pol_bits()), 64'({ROWS{frame_o}}));
      chk(in_o == s[in_end], "R8", "input-end port carries loaded pulse", 64'(in_o), 64'(s[in_end]));
      chk(out_o == s[out_end], "R8", "output-end port carries last stage", 64'(out_o), 64'(s[out_end]));
      if (have_pos) begin
        nxt = d ? (pos + 1) % ROWS : (pos + ROWS - 1) % ROWS;
        chk(s == (ROWS'(1) << nxt), "R10", "token advances one row", 64'(s), 64'(ROWS'(1) << nxt));
        pos = nxt;
      end else if (s != '0) begin
        for (int i = 0; i < ROWS; i++) if (s[i]) pos = i;
        have_pos = 1'b1;
        chk(pos == in_end, "R10", "token loads at input end", 64'(pos), 64'(in_end));
      end
      if (have_pos && pos == in_end) begin
        if (have_entry)
          chk(frame_o != last_m, "R11", "polarity toggles per frame", 64'(frame_o), 64'(~last_m));
        last_m = frame_o;
        have_entry = 1'b1;
      end
    end
    chk(have_pos && have_entry, "R10", "token observed", 64'({have_pos, have_entry}), 64'h3);
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset holds codes at zero even with polarity input high
    rst = 1'b1; frame_i = 1'b1;
    wait_cyc(4);
    chk(row_code == '0, "R1", "codes during reset", 64'(row_code), 64'(0));
    frame_i = 1'b0;

    // Vector table: slave shifting in both directions and both phases
    for (int v = 0; v < 6; v++) begin
      do_reset(1'b0, VEC[v][9], VEC[v][8]);
      chk(row_code == '0, "R1", "codes after reset", 64'(row_code), 64'(0));
      for (int k = 0; k < 8; k++) shift_bit(VEC[v][k]);
      chk(sel_bits() == mdl, VEC[v][9] ? "R2" : "R3", "final rows", 64'(sel_bits()), 64'(mdl));
      chk(!frame_oe && !scl_oe && (left_oe == !dir_i) && (right_oe == dir_i), "R6",
          "slave enables", 64'({frame_oe, scl_oe, left_oe, right_oe}),
          64'({2'b00, !dir_i, dir_i}));
    end

    // R9: slave polarity follows frame_i, code layout {select, polarity}
    do_reset(1'b0, 1'b1, 1'b1);
    frame_i = 1'b1;
    wait_cyc(SETTLE);
    chk(pol_bits() == '1, "R9", "polarity bits follow frame_i=1", 64'(pol_bits()), 64'({ROWS{1'b1}}));
    shift_bit(1'b1);
    chk(row_code[1:0] == 2'b11, "R9", "row 0 code selected/pol1", 64'(row_code[1:0]), 64'h3);
    chk(row_code[3:2] == 2'b01, "R9", "row 1 code idle/pol1", 64'(row_code[3:2]), 64'h1);
    frame_i = 1'b0;
    wait_cyc(SETTLE);
    chk(pol_bits() == '0, "R9", "polarity bits follow frame_i=0", 64'(pol_bits()), 64'(0));

    // R8: token emerges at the output-end port in slave mode, both directions
    for (int dd = 0; dd < 2; dd++) begin
      do_reset(1'b0, logic'(dd), 1'b1);
      shift_bit(1'b1);
      for (int k = 0; k < ROWS - 1; k++) shift_bit(1'b0);
      chk((dd ? right_o : left_o) == 1'b1, "R8", "tail reaches output port",
          64'(dd ? right_o : left_o), 64'h1);
      shift_bit(1'b0);
      chk((dd ? right_o : left_o) == 1'b0, "R8", "tail leaves output port",
          64'(dd ? right_o : left_o), 64'h0);
      chk(sel_bits() == '0, dd ? "R2" : "R3", "chain empty after exit", 64'(sel_bits()), 64'(0));
    end

    // Master mode runs: R7, R8, R10, R11, R12
    master_run(1'b1, 1'b1);
    master_run(1'b0, 1'b0);
    master_run(1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule